// File: doc/BRIEF.md
# UART FIFO Interrupt and DMA Request Generator

This block sits beside a FIFO-based serial port. It turns the port's status flags into four separate interrupt request lines and two DMA transfer request lines. The flags are: transmit FIFO empty, receive FIFO full, receive data ready, receive error, break detected and overrun. The FIFOs, the shift logic, baud generation, the DMA controller and the interrupt controller are all outside this block. The block only decides which requests are raised.

A DMA request always follows its status flag, whatever the matching interrupt enable says. This lets a DMA engine move data while the processor's interrupt stays masked. A separate error enable lets software take error and break interrupts without taking receive-data interrupts. A DMA acknowledge strobe retires the pending interrupt for the same direction, so no software handler has to run.

An encoded output gives the highest-priority active interrupt, with a valid bit, so that a single handler can dispatch.

Top module: `uart_irq_dma_gen`

## Requirements
- R1: The four interrupt outputs `irq_err`, `irq_rx`, `irq_brk` and `irq_tx` each follow only their own conditions. Any combination of them can be active at once.
- R2: `dreq_tx` is 1 whenever `tx_empty` was 1, whatever the value of `tx_ie`. `irq_tx` is 1 only when `tx_empty` and `tx_ie` were both 1.
- R3: The receive condition is `rx_full`, or `rx_ready` in asynchronous mode. `dreq_rx` is 1 whenever the receive condition held, whatever the value of `rx_ie`. `irq_rx` is 1 only when the receive condition held and `rx_ie` was 1.
- R4: When `sync_mode` is 1 (clocked synchronous mode), `rx_ready` has no effect on `irq_rx` or `dreq_rx`. When `sync_mode` is 0 (asynchronous mode), `rx_ready` counts like `rx_full`.
- R5: `irq_brk` is 1 when `brk_det` or `ovr_err` was 1 and the error interrupts are enabled.
- R6: `irq_err` and `irq_brk` are enabled when `rx_ie` or `err_ie` is 1. Both are masked only when both enables are 0. With `rx_ie` at 0 and `err_ie` at 1, `irq_rx` stays 0.
- R7: When `tx_ack` or `rx_ack` is 1 in a cycle, the DMA request and the interrupt of that direction are 0 in the next cycle. They return one cycle later if the flag is still set.
- R8: `top_src` gives the highest-priority active interrupt, in the order ERI (code 0, `irq_err`), RXI (code 1, `irq_rx`), BRI (code 2, `irq_brk`), TXI (code 3, `irq_tx`). `top_vld` is 0, and `top_src` is 0, when no interrupt is active.
- R9: While `rst_n` is low at a rising edge, every request output and `top_vld` become 0 at that edge.
- R10: Every request output is registered. It shows the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_ready | input | 1 | Receive data ready flag |
| rx_err | input | 1 | Receive error flag |
| brk_det | input | 1 | Break detected flag |
| ovr_err | input | 1 | Overrun error flag |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error-only interrupt enable |
| sync_mode | input | 1 | 1 = clocked synchronous mode, 0 = asynchronous mode |
| tx_ack | input | 1 | Transmit DMA acknowledge strobe |
| rx_ack | input | 1 | Receive DMA acknowledge strobe |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_err | output | 1 | Receive error interrupt request |
| irq_rx | output | 1 | Receive data interrupt request |
| irq_brk | output | 1 | Break or overrun interrupt request |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |
| top_src | output | 2 | Code of the highest-priority active interrupt |
| top_vld | output | 1 | 1 when any interrupt is active |

## Verification
Each request output, including the cleared state after an acknowledge, is due one rising edge after the inputs that cause it. The encoded source and its valid bit settle in the same cycle as the interrupts they summarise.

The bench changes its inputs just after a falling edge. A behavioural model recomputes the expected outputs at each rising edge from the inputs held at that edge. The bench compares every output at the following falling edge, so each check falls exactly one edge after its stimulus.

// File: rtl/uart_irq_pkg.sv
// Package: shared source codes for the UART interrupt and DMA request generator.
// Assumes: code order equals priority order, 0 is the highest priority.
package uart_irq_pkg;
    localparam int NUM_SRC = 4;
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef enum logic [SRC_W-1:0] {
        SRC_ERR = 2'd0,
        SRC_RX  = 2'd1,
        SRC_BRK = 2'd2,
        SRC_TX  = 2'd3
    } irq_src_e;
endpackage

// File: rtl/uart_req_channel.sv
// Module: one data direction's request pair (interrupt plus DMA request).
// The DMA request follows the condition alone. The interrupt also needs the enable.
// An acknowledge blanks both for the next cycle.
// Assumes: ack is a single-cycle strobe, synchronous to clk.
module uart_req_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic ie,
    input  logic ack,
    output logic irq_q,
    output logic dreq_q
);
    logic live;

    // Purpose: the condition counts unless an acknowledge retires it this cycle.
    always_comb begin
        live = cond && !ack;
    end

    // Purpose: register both requests, with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            dreq_q <= 1'b0;
        end else begin
            irq_q  <= live && ie;
            dreq_q <= live;
        end
    end

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!irq_q && !dreq_q)); // R7
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie) |=> !irq_q); // R2
    AST_DREQ_IGNORES_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !ack) |=> dreq_q); // R3
endmodule

// File: rtl/uart_status_irq.sv
// Module: registered status interrupts that share one enable (error and break group).
// Assumes: the flag inputs are already level signals from the status register.
module uart_status_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag,
    input  logic         en,
    output logic [N-1:0] irq_q
);
    for (genvar g = 0; g < N; g++) begin : g_src
        // Purpose: one registered request per status source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q[g] <= 1'b0;
            end else begin
                irq_q[g] <= flag[g] && en;
            end
        end

        AST_MASKED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!en) |=> !irq_q[g]); // R6
    end
endmodule

// File: rtl/uart_prio_enc.sv
// Module: fixed-priority encoder. Index 0 is the highest priority.
// Assumes: req comes from registers, so the output has no path from the block inputs.
module uart_prio_enc #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] code,
    output logic         vld
);
    // Purpose: scan from lowest to highest priority so the highest active one wins.
    always_comb begin
        code = '0;
        vld  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                code = W'(i);
                vld  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_irq_dma_gen.sv
// Module: UART FIFO interrupt and DMA request generator (top).
// It maps serial status flags to four interrupt lines and two DMA requests,
// and reports the highest-priority active interrupt.
// Assumes: all flags and strobes are synchronous to clk. Reset is synchronous, active low.
module uart_irq_dma_gen
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_empty,
    input  logic             rx_full,
    input  logic             rx_ready,
    input  logic             rx_err,
    input  logic             brk_det,
    input  logic             ovr_err,
    input  logic             tx_ie,
    input  logic             rx_ie,
    input  logic             err_ie,
    input  logic             sync_mode,
    input  logic             tx_ack,
    input  logic             rx_ack,
    output logic             irq_tx,
    output logic             irq_err,
    output logic             irq_rx,
    output logic             irq_brk,
    output logic             dreq_tx,
    output logic             dreq_rx,
    output logic [SRC_W-1:0] top_src,
    output logic             top_vld
);
    logic               rx_cond;
    logic               err_en;
    logic [1:0]         stat_flag;
    logic [1:0]         stat_irq;
    logic [NUM_SRC-1:0] prio_req;

    // Purpose: form the receive condition (data ready counts in asynchronous mode only)
    // and the shared error enable.
    always_comb begin
        rx_cond   = rx_full || (rx_ready && !sync_mode);
        err_en    = rx_ie || err_ie;
        stat_flag = {brk_det || ovr_err, rx_err};
    end

    uart_req_channel u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (tx_empty),
        .ie     (tx_ie),
        .ack    (tx_ack),
        .irq_q  (irq_tx),
        .dreq_q (dreq_tx)
    );

    uart_req_channel u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (rx_cond),
        .ie     (rx_ie),
        .ack    (rx_ack),
        .irq_q  (irq_rx),
        .dreq_q (dreq_rx)
    );

    uart_status_irq #(.N(2)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (stat_flag),
        .en    (err_en),
        .irq_q (stat_irq)
    );

    // Purpose: split the status group outputs and pack the requests in priority order.
    always_comb begin
        irq_err  = stat_irq[0];
        irq_brk  = stat_irq[1];
        prio_req = '0;
        prio_req[SRC_ERR] = irq_err;
        prio_req[SRC_RX]  = irq_rx;
        prio_req[SRC_BRK] = irq_brk;
        prio_req[SRC_TX]  = irq_tx;
    end

    uart_prio_enc #(.N(NUM_SRC)) u_enc (
        .req  (prio_req),
        .code (top_src),
        .vld  (top_vld)
    );

    AST_SYNC_READY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !rx_full) |=> (!dreq_rx && !irq_rx)); // R4
    AST_ERR_ONLY_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie) |=> !irq_rx); // R6
    AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (top_vld && top_src == SRC_ERR)); // R8
    AST_TX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (top_vld && top_src == SRC_TX) |-> (!irq_err && !irq_rx && !irq_brk)); // R8
    AST_BRK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_det && !ovr_err) |=> !irq_brk); // R5
endmodule

// File: tb/uart_irq_dma_gen_tb.sv
module uart_irq_dma_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_empty = 0, rx_full = 0, rx_ready = 0, rx_err = 0, brk_det = 0, ovr_err = 0;
    logic tx_ie = 0, rx_ie = 0, err_ie = 0, sync_mode = 0, tx_ack = 0, rx_ack = 0;
    logic irq_tx, irq_err, irq_rx, irq_brk, dreq_tx, dreq_rx, top_vld;
    logic [1:0] top_src;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R9";

    // expected values, produced by the behavioural model
    bit e_irq_tx, e_irq_err, e_irq_rx, e_irq_brk, e_dreq_tx, e_dreq_rx, e_vld;
    int e_src;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_dma_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_ready(rx_ready), .rx_err(rx_err), .brk_det(brk_det), .ovr_err(ovr_err),
        .tx_ie(tx_ie), .rx_ie(rx_ie), .err_ie(err_ie), .sync_mode(sync_mode),
        .tx_ack(tx_ack), .rx_ack(rx_ack), .irq_tx(irq_tx), .irq_err(irq_err),
        .irq_rx(irq_rx), .irq_brk(irq_brk), .dreq_tx(dreq_tx), .dreq_rx(dreq_rx),
        .top_src(top_src), .top_vld(top_vld)
    );

    // Reference model: evaluated at each rising edge from the inputs held there (R10).
    always @(posedge clk) begin
        int pend[$];
        bit rxc, een;
        if (!rst_n) begin
            e_irq_tx = 0; e_irq_err = 0; e_irq_rx = 0; e_irq_brk = 0;
            e_dreq_tx = 0; e_dreq_rx = 0;
        end else begin
            rxc = rx_full || (sync_mode ? 1'b0 : rx_ready);
            een = rx_ie || err_ie;
            e_dreq_tx = tx_ack ? 0 : tx_empty;
            e_irq_tx  = e_dreq_tx && tx_ie;
            e_dreq_rx = rx_ack ? 0 : rxc;
            e_irq_rx  = e_dreq_rx && rx_ie;
            e_irq_err = een && rx_err;
            e_irq_brk = een && (brk_det || ovr_err);
        end
        pend.delete();
        if (e_irq_err) pend.push_back(0);
        if (e_irq_rx)  pend.push_back(1);
        if (e_irq_brk) pend.push_back(2);
        if (e_irq_tx)  pend.push_back(3);
        e_vld = pend.size() > 0;
        e_src = e_vld ? pend[0] : 0;
    end

    task automatic check1(string req, string nm, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s/%s %s: actual %0d expected %0d at %0t", phase, req, nm, act, exp, $time);
        end
    endtask

    // Compare on every falling edge, half a period after the outputs update.
    always @(negedge clk) begin
        check1("R2", "irq_tx", int'(irq_tx), int'(e_irq_tx));
        check1("R2", "dreq_tx", int'(dreq_tx), int'(e_dreq_tx));
        check1("R3", "irq_rx", int'(irq_rx), int'(e_irq_rx));
        check1("R3", "dreq_rx", int'(dreq_rx), int'(e_dreq_rx));
        check1("R6", "irq_err", int'(irq_err), int'(e_irq_err));
        check1("R5", "irq_brk", int'(irq_brk), int'(e_irq_brk));
        check1("R8", "top_vld", int'(top_vld), int'(e_vld));
        check1("R8", "top_src", int'(top_src), e_src);
    end

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clr_all();
        {tx_empty, rx_full, rx_ready, rx_err, brk_det, ovr_err} = '0;
        {tx_ie, rx_ie, err_ie, sync_mode, tx_ack, rx_ack} = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        phase = "R9";
        step(3);
        rst_n = 1'b1;
        // R2: DMA request regardless of enable, interrupt only with enable
        phase = "R2"; tx_empty = 1; step(3); tx_ie = 1; step(3); clr_all(); step(2);
        // R3: receive-full drives the DMA request, the interrupt needs rx_ie
        phase = "R3"; rx_full = 1; step(3); rx_ie = 1; step(3); rx_full = 0; rx_ready = 1; step(3);
        clr_all(); step(2);
        // R4: ready flag ignored in synchronous mode
        phase = "R4"; sync_mode = 1; rx_ready = 1; rx_ie = 1; step(4);
        sync_mode = 0; step(3); clr_all(); step(2);
        // R5: break or overrun
        phase = "R5"; rx_ie = 1; brk_det = 1; step(3); brk_det = 0; ovr_err = 1; step(3);
        clr_all(); step(2);
        // R6: error-only enable
        phase = "R6"; err_ie = 1; rx_err = 1; brk_det = 1; rx_full = 1; step(4);
        err_ie = 0; step(3); clr_all(); step(2);
        // R7: acknowledge retires, then reasserts while the flag holds
        phase = "R7"; tx_empty = 1; rx_full = 1; tx_ie = 1; rx_ie = 1; step(3);
        tx_ack = 1; step(1); tx_ack = 0; step(2);
        rx_ack = 1; step(1); rx_ack = 0; step(2);
        tx_ack = 1; rx_ack = 1; tx_empty = 0; step(1); tx_ack = 0; rx_ack = 0; step(3);
        clr_all(); step(2);
        // R8: every combination of the four sources
        phase = "R8"; rx_ie = 1; tx_ie = 1;
        for (int c = 0; c < 16; c++) begin
            rx_err = c[0]; rx_full = c[1]; brk_det = c[2]; tx_empty = c[3];
            step(2);
        end
        clr_all(); step(2);
        // R1 / R10: free-running random mix, every output checked every cycle
        phase = "R1";
        for (int c = 0; c < 3000; c++) begin
            {tx_empty, rx_full, rx_ready, rx_err, brk_det, ovr_err} = 6'($urandom());
            {tx_ie, rx_ie, err_ie, sync_mode} = 4'($urandom());
            tx_ack = ($urandom() % 4) == 0;
            rx_ack = ($urandom() % 4) == 0;
            step(1);
        end
        // R9: reset in mid run with flags active
        phase = "R9"; tx_empty = 1; rx_full = 1; rx_err = 1; tx_ie = 1; rx_ie = 1;
        rst_n = 1'b0; step(3); rst_n = 1'b1; step(3);
        clr_all(); step(2);
        finish_run();
    end
endmodule